// File: doc/BRIEF.md
# Frequency Order Lehmer-Gray Encoder

This block turns one batch of sixteen corrected oscillator frequency counts into a response word that records only their relative order. It accepts the whole batch in one valid/ready transfer and latches it. It then works through the items one at a time. For each item it counts how many earlier items have a strictly larger count. Each of these rank digits is Gray coded and placed in its own field of a 49-bit raw response.

An ordering of sixteen items carries only about 44.3 bits of entropy, so the raw word has spare bits. A fixed XOR fold merges the most significant Gray bit of the least-used digit fields into the bit below it. This gives a 42-bit compressed response, or a 40-bit one when the narrow option is set. Both the raw and the compressed words come out together with a one-cycle valid pulse. A downstream error-correction stage takes either word.

Top module: `freq_order_encoder`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A batch is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low until the result is presented, and `in_valid` asserted while busy starts no new batch.
- R2: `out_valid` is a single-cycle pulse. It is raised by the 16th rising edge after the accepting edge and counts that edge as the first, so one batch per 16 cycles is sustained.
- R3: Rank digit i (i = 1..15) equals the number of items j < i whose count is strictly greater than the count of item i. Counts are unsigned, item j sits at `in_counts[j*CNT_W +: CNT_W]`, and the digit lies in 0..i.
- R4: Equal counts are ordered by index: the lower index is treated as smaller. An earlier item with the same count therefore never adds to a digit.
- R5: Digit i occupies ceil(log2(i+1)) bits of `out_raw`, starting at the sum of the widths of digits 1..i-1. Digit 1 is at bit 0, digit 15 at bits 48:45, and the fields total 49 bits.
- R6: Each digit is stored Gray coded as g = b XOR (b >> 1), independently of the others.
- R7: In the default mode the fields of digits 8..14 are folded: the top two Gray bits are XORed into one bit and the top bit is dropped. All fields are then concatenated in digit order from bit 0 of `out_comp`, which gives 42 bits.
- R8: With NARROW set, digits 4 and 5 are also folded the same way, which makes `out_comp` 40 bits wide.
- R9: After reset `out_valid` is low and `in_ready` is high.
- R10: The batch is held internally from the accepting edge. Changes on `in_counts` after that edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Block idle, batch can be taken |
| in_counts | input | 16*CNT_W | Sixteen unsigned counts, item j at bits j*CNT_W upward |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_raw | output | 49 | Gray-coded rank digits, unfolded |
| out_comp | output | 42 (40 if NARROW) | Folded response |

## Verification
The hardest cases to reach from the ports are the tie rule and the extreme digit values. Counts drawn from a wide random range almost never repeat, and they almost never put a digit at 0 or i. The stimulus therefore mixes strictly ascending and strictly descending batches, which drive every digit to its minimum and its maximum. It also uses batches whose counts are all equal and random batches drawn from only four values, which force many ties. Two instances, one per fold mode, are driven by the same stimulus. Junk is held on the input while the block is busy, so any batch taken by mistake shows up as an extra result.

// File: rtl/foe_pkg.sv
package foe_pkg;

  localparam int N_ITEMS = 16;
  localparam int IDX_W   = $clog2(N_ITEMS);
  localparam int DIG_W   = $clog2(N_ITEMS);

  function automatic int dig_w(input int i);
    return $clog2(i + 1);
  endfunction

  function automatic int dig_off(input int i);
    int s;
    s = 0;
    for (int k = 1; k < i; k++) s += dig_w(k);
    return s;
  endfunction

  // Fields whose value range wastes the most of their width.
  function automatic bit is_folded(input int i, input bit narrow);
    return (i >= 8 && i <= 14) || (narrow && (i == 4 || i == 5));
  endfunction

  function automatic int comp_off(input int i, input bit narrow);
    int s;
    s = 0;
    for (int k = 1; k < i; k++) s += dig_w(k) - (is_folded(k, narrow) ? 1 : 0);
    return s;
  endfunction

  function automatic int comp_width(input bit narrow);
    return comp_off(N_ITEMS, narrow);
  endfunction

  localparam int RAW_W = dig_off(N_ITEMS);

  function automatic logic [DIG_W-1:0] to_gray(input logic [DIG_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/foe_rank_unit.sv
module foe_rank_unit #(
  parameter int CNT_W = 16,
  localparam int N    = foe_pkg::N_ITEMS,
  localparam int IW   = foe_pkg::IDX_W,
  localparam int DW   = foe_pkg::DIG_W
) (
  input  logic [N*CNT_W-1:0] cnt_flat,
  input  logic [IW-1:0]      idx,
  output logic [N-2:0]       gt_vec,
  output logic [DW-1:0]      digit
);

  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = cnt_flat[idx*CNT_W +: CNT_W];

  genvar j;
  generate
    for (j = 0; j < N - 1; j++) begin : g_cmp
      assign gt_vec[j] = (IW'(j) < idx) && (cnt_flat[j*CNT_W +: CNT_W] > sel_cnt);
    end
  endgenerate

  always_comb begin
    digit = '0;
    for (int k = 0; k < N - 1; k++) digit = digit + DW'(gt_vec[k]);
  end

endmodule

// File: rtl/foe_fold.sv
module foe_fold #(
  parameter bit  NARROW = 1'b0,
  localparam int RW     = foe_pkg::RAW_W,
  localparam int CW     = foe_pkg::comp_width(NARROW)
) (
  input  logic [RW-1:0] raw_in,
  output logic [CW-1:0] comp_out
);

  genvar k;
  generate
    for (k = 1; k < foe_pkg::N_ITEMS; k++) begin : g_field
      localparam int W  = foe_pkg::dig_w(k);
      localparam int IO = foe_pkg::dig_off(k);
      localparam int OO = foe_pkg::comp_off(k, NARROW);
      if (foe_pkg::is_folded(k, NARROW)) begin : g_fold
        assign comp_out[OO +: W-1] = {raw_in[IO+W-1] ^ raw_in[IO+W-2], raw_in[IO +: W-2]};
      end else begin : g_copy
        assign comp_out[OO +: W] = raw_in[IO +: W];
      end
    end
  endgenerate

endmodule

// File: rtl/freq_order_encoder.sv
module freq_order_encoder #(
  parameter int  CNT_W  = 16,
  parameter bit  NARROW = 1'b0,
  localparam int N      = foe_pkg::N_ITEMS,
  localparam int RW     = foe_pkg::RAW_W,
  localparam int CW     = foe_pkg::comp_width(NARROW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N*CNT_W-1:0] in_counts,
  output logic               out_valid,
  output logic [RW-1:0]      out_raw,
  output logic [CW-1:0]      out_comp
);

  localparam int IW = foe_pkg::IDX_W;
  localparam int DW = foe_pkg::DIG_W;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t             state_q;
  logic [IW-1:0]      idx_q;
  logic [N*CNT_W-1:0] cnt_q;
  logic [RW-1:0]      raw_q;
  logic [RW-1:0]      raw_next;
  logic [CW-1:0]      comp_next;

  // Named events for the checker.
  logic          in_fire;
  logic          step_valid;
  logic          last_step;
  logic [N-2:0]  gt_vec;
  logic [DW-1:0] rank_digit;
  logic [DW-1:0] rank_gray;

  assign in_ready   = (state_q == ST_IDLE);
  assign in_fire    = in_valid && in_ready;
  assign step_valid = (state_q == ST_RUN);
  assign last_step  = step_valid && (idx_q == IW'(N - 1));

  foe_rank_unit #(.CNT_W(CNT_W)) u_rank (
    .cnt_flat (cnt_q),
    .idx      (idx_q),
    .gt_vec   (gt_vec),
    .digit    (rank_digit)
  );

  assign rank_gray = foe_pkg::to_gray(rank_digit);

  genvar k;
  generate
    for (k = 1; k < N; k++) begin : g_slot
      localparam int W  = foe_pkg::dig_w(k);
      localparam int OF = foe_pkg::dig_off(k);
      assign raw_next[OF +: W] = (step_valid && idx_q == IW'(k)) ? rank_gray[W-1:0]
                                                                 : raw_q[OF +: W];
    end
  endgenerate

  foe_fold #(.NARROW(NARROW)) u_fold (
    .raw_in   (raw_next),
    .comp_out (comp_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      raw_q     <= '0;
      out_valid <= 1'b0;
      out_raw   <= '0;
      out_comp  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_fire) begin
            cnt_q   <= in_counts;
            idx_q   <= IW'(1);
            state_q <= ST_RUN;
          end
        end
        default: begin
          raw_q <= raw_next;
          if (last_step) begin
            out_valid <= 1'b1;
            out_raw   <= raw_next;
            out_comp  <= comp_next;
            state_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/foe_checker.sv
module foe_checker #(
  parameter int IW = 4,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          step_valid,
  input logic [IW-1:0] step_idx,
  input logic [DW-1:0] step_digit
);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r1_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (step_valid && step_idx == IW'(1)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 16));

  a_r1_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  a_r3_digit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (step_digit <= DW'(step_idx)));

endmodule

bind freq_order_encoder foe_checker #(.IW(foe_pkg::IDX_W), .DW(foe_pkg::DIG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .step_valid (step_valid),
  .step_idx   (idx_q),
  .step_digit (rank_digit)
);

// File: tb/freq_order_encoder_tb.sv
`timescale 1ns/1ps
module freq_order_encoder_tb;

  localparam int CW = 16;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NI*CW-1:0] in_counts = '0;
  logic in_ready, in_ready_n, out_valid, out_valid_n;
  logic [48:0] out_raw, out_raw_n;
  logic [41:0] out_comp;
  logic [39:0] out_comp_n;

  always #10 clk = ~clk;

  freq_order_encoder #(.CNT_W(CW), .NARROW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_counts(in_counts), .out_valid(out_valid), .out_raw(out_raw), .out_comp(out_comp));

  freq_order_encoder #(.CNT_W(CW), .NARROW(1'b1)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_n),
    .in_counts(in_counts), .out_valid(out_valid_n), .out_raw(out_raw_n), .out_comp(out_comp_n));

  typedef struct {
    logic [48:0] raw;
    logic [41:0] c42;
    logic [39:0] c40;
    int          t0;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0, n_out = 0, n_sent = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model built from the requirements.
  function automatic logic [48:0] m_raw(input logic [NI*CW-1:0] c);
    logic [48:0] r;
    int pos;
    r = '0;
    pos = 0;
    for (int i = 1; i < NI; i++) begin
      int d, w;
      logic [3:0] g;
      d = 0;
      for (int j = 0; j < i; j++)
        if (c[j*CW +: CW] > c[i*CW +: CW]) d++;
      g = 4'(d) ^ (4'(d) >> 1);
      w = $clog2(i + 1);
      for (int b = 0; b < w; b++) r[pos+b] = g[b];
      pos += w;
    end
    return r;
  endfunction

  function automatic logic [48:0] m_comp(input logic [48:0] r, input bit narrow);
    logic [48:0] o;
    int pi, po;
    o = '0;
    pi = 0;
    po = 0;
    for (int i = 1; i < NI; i++) begin
      int w;
      bit f;
      w = $clog2(i + 1);
      f = (i >= 8 && i <= 14) || (narrow && (i == 4 || i == 5));
      if (f) begin
        for (int b = 0; b < w - 2; b++) o[po+b] = r[pi+b];
        o[po+w-2] = r[pi+w-2] ^ r[pi+w-1];
        po += w - 1;
      end else begin
        for (int b = 0; b < w; b++) o[po+b] = r[pi+b];
        po += w;
      end
      pi += w;
    end
    return o;
  endfunction

  task automatic send(input logic [NI*CW-1:0] c);
    exp_t e;
    logic [48:0] t42, t40;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_counts = c;
    in_valid  = 1'b1;
    e.raw = m_raw(c);
    t42 = m_comp(e.raw, 1'b0);
    t40 = m_comp(e.raw, 1'b1);
    e.c42 = t42[41:0];
    e.c40 = t40[39:0];
    e.t0  = cyc;
    q.push_back(e);
    n_sent++;
    @(negedge clk);
    in_valid  = 1'b0;
    in_counts = ~c ^ {NI{16'h5a3c}};  // R10: scramble after acceptance
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_out++;
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected result", 64'(out_raw), 64'd0);
      end else begin
        e = q.pop_front();
        chk(out_raw == e.raw, "R3/R4/R5/R6/R10 raw", 64'(out_raw), 64'(e.raw));
        chk(out_comp == e.c42, "R7 comp42", 64'(out_comp), 64'(e.c42));
        chk(out_valid_n && out_comp_n == e.c40, "R8 comp40", 64'(out_comp_n), 64'(e.c40));
        chk(out_raw_n == e.raw, "R8 raw narrow", 64'(out_raw_n), 64'(e.raw));
        chk(cyc - e.t0 == 16, "R2 latency", 64'(cyc - e.t0), 64'd16);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NI*CW-1:0] v;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R9 no valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R9 idle after release", 64'({in_ready, out_valid}), 64'd2);

    // Ascending: all digits zero
    for (int j = 0; j < NI; j++) v[j*CW +: CW] = 16'(100 + j * 7);
    send(v);
    // Descending: digit i equals i (R3 maximum)
    for (int j = 0; j < NI; j++) v[j*CW +: CW] = 16'(60000 - j * 3);
    send(v);
    while (!out_valid) @(negedge clk);
    @(negedge clk);
    // R5/R6: descending puts Gray(15)=1000 at bits 48:45 and Gray(1)=1 at bit 0
    chk(out_raw[48:45] == 4'b1000, "R5 R6 digit15 field", 64'(out_raw[48:45]), 64'h8);
    chk(out_raw[0] == 1'b1, "R5 digit1 field", 64'(out_raw[0]), 64'd1);
    // All equal: R4 ties give zero
    send({NI{16'h1234}});
    // Pair ties
    for (int j = 0; j < NI; j++) v[j*CW +: CW] = (j % 2 == 0) ? 16'd7 : 16'd3;
    send(v);
    // Extreme counts
    for (int j = 0; j < NI; j++) v[j*CW +: CW] = (j % 3 == 0) ? 16'hffff : 16'h0000;
    send(v);

    // R1: junk offered while busy must start nothing
    for (int j = 0; j < NI; j++) v[j*CW +: CW] = 16'(j * 11);
    send(v);
    in_valid = 1'b1;
    in_counts = {NI{16'hdead}};
    repeat (10) @(negedge clk);
    chk(in_ready == 1'b0, "R1 busy while running", 64'(in_ready), 64'd0);
    in_valid = 1'b0;

    // Random wide and random tie-heavy batches, back to back
    for (int t = 0; t < 30; t++) begin
      for (int j = 0; j < NI; j++)
        v[j*CW +: CW] = (t % 2 == 0) ? 16'($urandom) : 16'($urandom_range(0, 3));
      send(v);
    end

    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(n_out == n_sent, "R1 result count", 64'(n_out), 64'(n_sent));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule